// File: doc/BRIEF.md
# Start-up Delay Timer

This block holds back the core clock after a reset and after a wake-up from a sleep mode. It counts oscillator cycles until the oscillator and the supply have had time to settle. After a reset it counts a base number of cycles and may add a further wait of a few milliseconds. A 2-bit start-up code selects that extra wait. After a wake-up request it counts only a short fixed number of cycles.

The start-up code is captured once, on the first clock edge after reset is released. Changes to the code after that edge have no effect until the next reset. One code value is reserved. If it is selected, the block falls back to the longest reset delay and raises an error flag. The millisecond waits are parameters given in oscillator cycles: at the nominal 128 kHz, 4 ms is 512 cycles and 64 ms is 8192 cycles. A bench can therefore scale them down.

When a count finishes, the block gives a one-cycle ready strobe. At the end of the reset count it also raises a reset-release level, which then stays high until the next reset.

Top module: `startup_timer`

## Requirements
- R1: While rst_ni is low, clk_ready_o, rst_release_o and code_err_o are all low.
- R2: The start-up code on sut_i is sampled on the first rising clock edge after rst_ni goes high. Values on sut_i before or after that edge do not change the delay.
- R3: With code 2'b00, clk_ready_o is high during the cycle that follows rising edge 1+RST_CYC after reset release. The edge that samples the code is edge 1.
- R4: With code 2'b01, the strobe comes after edge 1+RST_CYC+MS_SHORT_CYC.
- R5: With code 2'b10, the strobe comes after edge 1+RST_CYC+MS_LONG_CYC.
- R6: Code 2'b11 is reserved. It uses the 2'b10 delay and sets code_err_o from the sampling edge onward. The flag stays high until the next reset and is low after a reset that samples a valid code.
- R7: clk_ready_o is high for exactly one cycle per completed count. rst_release_o rises in the same cycle as the reset-count strobe and stays high until reset.
- R8: Once reset is released and no count is running, a wake_i pulse sampled at edge k gives a strobe after edge k+WAKE_CYC.
- R9: wake_i is ignored while a reset count or a wake count is running. It neither moves the pending strobe nor causes an extra one.
- R10: Asserting rst_ni during a count aborts the count. After release the reset profile restarts from zero.
- R11: Outside a completed count, clk_ready_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset request, active low |
| wake_i | input | 1 | Wake-up request from a sleep mode |
| sut_i | input | 2 | Start-up profile code |
| clk_ready_o | output | 1 | One-cycle strobe when a delay completes |
| rst_release_o | output | 1 | High once the reset delay has completed |
| code_err_o | output | 1 | Reserved start-up code was sampled |

## Verification
The reset delay is measured for all four code values with distinct millisecond parameters. Separate base, short and long lengths show that each code picks its own profile. Matching lengths for codes 2'b10 and 2'b11, together with the flag, show the reserved-code fallback. The code input is changed just before and just after the sampling edge, which tells the sampled value apart from a live decode. Wake pulses are applied when the block is idle, in the middle of a wake count and in the middle of a reset count. These separate a honoured request from an ignored one, and a mid-count reset shows that the count restarts rather than resumes.

// File: rtl/startup_timer_pkg.sv
package startup_timer_pkg;
  typedef enum logic [1:0] {
    ST_LATCH = 2'd0,
    ST_RST   = 2'd1,
    ST_IDLE  = 2'd2,
    ST_WAKE  = 2'd3
  } st_e;

  typedef enum logic [1:0] {
    SUT_BOD  = 2'b00,
    SUT_FAST = 2'b01,
    SUT_SLOW = 2'b10,
    SUT_RSV  = 2'b11
  } sut_e;
endpackage

// File: rtl/sut_decode.sv
module sut_decode
  import startup_timer_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int RST_CYC      = 14,
  parameter int MS_SHORT_CYC = 512,
  parameter int MS_LONG_CYC  = 8192
) (
  input  sut_e             code_i,
  output logic [CNT_W-1:0] tgt_o,
  output logic             err_o
);
  localparam logic [CNT_W-1:0] TGT_BASE  = CNT_W'(RST_CYC);
  localparam logic [CNT_W-1:0] TGT_SHORT = CNT_W'(RST_CYC + MS_SHORT_CYC);
  localparam logic [CNT_W-1:0] TGT_LONG  = CNT_W'(RST_CYC + MS_LONG_CYC);

  always_comb begin
    err_o = 1'b0;
    unique case (code_i)
      SUT_BOD:  tgt_o = TGT_BASE;
      SUT_FAST: tgt_o = TGT_SHORT;
      SUT_SLOW: tgt_o = TGT_LONG;
      default: begin
        tgt_o = TGT_LONG; // reserved: fall back to longest
        err_o = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/cycle_counter.sv
module cycle_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] tgt_i,
  output logic             busy_o,
  output logic             last_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] tgt_q;

  assign last_o = busy_o && (cnt_q == tgt_q - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tgt_q  <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (load_i) begin
        cnt_q  <= '0;
        tgt_q  <= tgt_i;
        busy_o <= 1'b1;
      end else if (last_o) begin
        busy_o <= 1'b0;
        done_o <= 1'b1;
      end else if (busy_o) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  // R9
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cnt_q < tgt_q));

  // R7
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/startup_fsm.sv
module startup_fsm
  import startup_timer_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wake_i,
  input  logic last_i,
  input  logic dec_err_i,
  output logic latch_o,
  output logic load_o,
  output logic rel_o,
  output logic err_o
);
  st_e st_q, st_d;

  assign latch_o = (st_q == ST_LATCH);
  assign load_o  = latch_o || (st_q == ST_IDLE && wake_i);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_LATCH: st_d = ST_RST;
      ST_RST:   if (last_i) st_d = ST_IDLE;
      ST_IDLE:  if (wake_i) st_d = ST_WAKE;
      ST_WAKE:  if (last_i) st_d = ST_IDLE;
      default:  st_d = ST_LATCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_LATCH;
      rel_o <= 1'b0;
      err_o <= 1'b0;
    end else begin
      st_q <= st_d;
      if (latch_o) err_o <= dec_err_i;
      if (st_q == ST_RST && last_i) rel_o <= 1'b1;
    end
  end

  // R6
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_LATCH) |=> $stable(err_o));

  // R8
  wake_after_rel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAKE) |-> rel_o);
endmodule

// File: rtl/startup_timer.sv
module startup_timer
  import startup_timer_pkg::*;
#(
  parameter int WAKE_CYC     = 6,
  parameter int RST_CYC      = 14,
  parameter int MS_SHORT_CYC = 512,
  parameter int MS_LONG_CYC  = 8192
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wake_i,
  input  logic [1:0] sut_i,
  output logic       clk_ready_o,
  output logic       rst_release_o,
  output logic       code_err_o
);
  localparam int MS_MAX = (MS_LONG_CYC > MS_SHORT_CYC) ? MS_LONG_CYC : MS_SHORT_CYC;
  localparam int CYC_MAX = (RST_CYC + MS_MAX > WAKE_CYC) ? RST_CYC + MS_MAX : WAKE_CYC;
  localparam int CNT_W = $clog2(CYC_MAX + 1);
  localparam logic [CNT_W-1:0] TGT_WAKE = CNT_W'(WAKE_CYC);

  logic [CNT_W-1:0] rst_tgt, tgt;
  logic dec_err, latch, load, busy, last, done;

  sut_decode #(
    .CNT_W(CNT_W), .RST_CYC(RST_CYC),
    .MS_SHORT_CYC(MS_SHORT_CYC), .MS_LONG_CYC(MS_LONG_CYC)
  ) u_dec (
    .code_i(sut_e'(sut_i)),
    .tgt_o (rst_tgt),
    .err_o (dec_err)
  );

  assign tgt = latch ? rst_tgt : TGT_WAKE;

  startup_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wake_i   (wake_i),
    .last_i   (last),
    .dec_err_i(dec_err),
    .latch_o  (latch),
    .load_o   (load),
    .rel_o    (rst_release_o),
    .err_o    (code_err_o)
  );

  cycle_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .tgt_i (tgt),
    .busy_o(busy),
    .last_o(last),
    .done_o(done)
  );

  assign clk_ready_o = done;

  // R7
  rel_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_release_o |=> rst_release_o);

  // R7
  rel_with_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_release_o) |-> clk_ready_o);

  // R11
  no_strobe_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !clk_ready_o);
endmodule

// File: tb/startup_timer_tb.sv
module startup_timer_tb;
  localparam int WAKE = 6;
  localparam int RSTC = 14;
  localparam int MSS  = 20;
  localparam int MSL  = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wake = 1'b0;
  logic [1:0] sut = 2'b00;
  logic rdy, rel, err;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  startup_timer #(
    .WAKE_CYC(WAKE), .RST_CYC(RSTC), .MS_SHORT_CYC(MSS), .MS_LONG_CYC(MSL)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wake_i(wake), .sut_i(sut),
    .clk_ready_o(rdy), .rst_release_o(rel), .code_err_o(err)
  );

  // {code, reset delay, error flag}: R3, R4, R5, R6
  typedef struct packed { logic [1:0] code; int unsigned dly; logic er; } vec_t;
  localparam vec_t VECS [4] = '{
    '{2'b00, RSTC,       1'b0},
    '{2'b01, RSTC + MSS, 1'b0},
    '{2'b10, RSTC + MSL, 1'b0},
    '{2'b11, RSTC + MSL, 1'b1}
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d exp %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // enter reset with code, check R1, release at negedge
  task automatic do_reset(logic [1:0] code);
    @(negedge clk);
    rst_n = 1'b0;
    sut = code;
    #1;
    chk("R1 outputs low in reset", {rdy, rel, err}, 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // edges until strobe; n counts edges from the next posedge
  task automatic measure(output int n, input int lim);
    n = 0;
    do begin
      @(posedge clk); #1;
      wake = 1'b0;
      n++;
    end while (!rdy && n < lim);
  endtask

  // count strobes over a window
  task automatic quiet(string req, int len);
    int cnt = 0;
    for (int i = 0; i < len; i++) begin
      @(posedge clk); #1;
      if (rdy) cnt++;
    end
    chk(req, cnt, 0);
  endtask

  initial begin
    #(8 * 20000);
    fails++;
    checks++;
    $display("FAIL watchdog: got 1 exp 0");
    summary();
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset state", {rdy, rel, err}, 0);

    foreach (VECS[i]) begin
      do_reset(VECS[i].code);
      measure(n, 500);
      chk("R3/R4/R5/R6 reset delay", n, 1 + int'(VECS[i].dly));
      chk("R7 release with strobe", rel, 1);
      chk("R6 error flag", err, VECS[i].er);
      @(posedge clk); #1;
      chk("R7 strobe one cycle", rdy, 0);
      chk("R7 release held", rel, 1);
    end

    // R6 flag cleared by reset with a valid code
    do_reset(2'b00);
    measure(n, 500);
    chk("R6 flag cleared", err, 0);

    // R8 wake from idle
    @(negedge clk); wake = 1'b1;
    measure(n, 100);
    chk("R8 wake delay", n, 1 + WAKE);

    // R9 second wake during wake count
    @(negedge clk); wake = 1'b1;
    n = 0;
    do begin
      @(posedge clk); #1;
      n++;
      wake = (n == 3);
    end while (!rdy && n < 100);
    wake = 1'b0;
    chk("R9 wake during wake", n, 1 + WAKE);
    quiet("R9 no extra strobe after wake", 12);

    // R9 wake during reset count
    do_reset(2'b00);
    n = 0;
    do begin
      @(posedge clk); #1;
      n++;
      wake = (n == 5);
    end while (!rdy && n < 100);
    wake = 1'b0;
    chk("R9 wake during reset", n, 1 + RSTC);
    quiet("R11 quiet after reset count", 12);

    // R10 reset in mid count restarts
    do_reset(2'b01);
    repeat (10) @(posedge clk);
    do_reset(2'b01);
    measure(n, 500);
    chk("R10 restart from zero", n, 1 + RSTC + MSS);

    // R2 code taken at first edge only
    @(negedge clk);
    rst_n = 1'b0;
    sut = 2'b10;
    @(negedge clk);
    rst_n = 1'b1;
    sut = 2'b00;
    n = 0;
    do begin
      @(posedge clk); #1;
      n++;
      sut = 2'b10;
    end while (!rdy && n < 500);
    chk("R2 sampled code", n, 1 + RSTC);

    // R2 late change to reserved code ignored
    do_reset(2'b01);
    @(posedge clk); #1;
    sut = 2'b11;
    n = 1;
    do begin
      @(posedge clk); #1;
      n++;
    end while (!rdy && n < 500);
    chk("R2 late change ignored", n, 1 + RSTC + MSS);
    chk("R2 no error flag", err, 0);

    summary();
  end
endmodule